// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the tag lookup stage of a small L1 data cache. Set selection begins from the virtual address as soon as a request arrives, while the translation unit computes the physical page number in parallel. The index and byte-offset fields fall wholly inside the page offset, which translation leaves unchanged, so the tags of the chosen set can be read before the physical page number is known. When translation reports back, the held tags are compared against the physical page number to produce a hit and a way number.

The default geometry is 128 sets of 4 ways with 32-byte lines, giving 16 KB. The 32-bit address splits into a 5-bit byte offset, a 7-bit set index and a 20-bit physical tag. A fill port installs a tag into the least recently used way of a set. After reset, a counter clears one set per cycle, and the block refuses requests until the sweep is complete.

Top module: `vipt_lookup`

## Requirements
- R1: The set index is taken from `req_vaddr[11:5]`. Bits [4:0] and bits [31:12] of the virtual address have no effect on which set is looked up.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until translation for that request has been presented.
- R3: The compare takes place in the first cycle with `xlat_valid`=1 after the request was taken, however many cycles later that is. The tags read at request time are held unchanged while the block waits.
- R4: A hit reports `resp_valid`=1 and `resp_hit`=1 only when a valid stored tag in the selected set equals `xlat_ppn`. `resp_way` then gives the way number (0..3). A miss gives `resp_hit`=0 and `resp_way`=0.
- R5: `xlat_fault`=1 together with `xlat_valid` cancels the lookup. No `resp_valid` is produced, the LRU state is untouched, and `req_ready` returns to 1 in the next cycle.
- R6: A fill (`fill_valid`=1) writes `fill_tag` as a valid tag into the least recently used way of set `fill_index`. That way is shown on `fill_victim` during the fill cycle, and it becomes the most recently used way.
- R7: A hit makes the hitting way the most recently used way of its set.
- R8: While `rst_n`=0 and for exactly 128 cycles after release, `req_ready` is 0. After that, every line is invalid. With no hits in between, successive fills to one set choose ways 3, 2, 1, 0, 3.
- R9: When a hit and a fill touch the same set in the same cycle, the fill victim is chosen from the LRU state before that cycle. The hit is applied first and the fill second, so the filled way ends most recently used and the hit way second.
- R10: A fill into the set of a pending lookup does not change that lookup's result. The result comes from the tags held at request time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the valid-clearing sweep |
| req_ready | output | 1 | Block can take a lookup request |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the request |
| xlat_valid | input | 1 | Translation result for the pending request |
| xlat_fault | input | 1 | Translation missed or faulted; cancel the lookup |
| xlat_ppn | input | 20 | Physical page number from translation |
| resp_valid | output | 1 | Lookup result valid this cycle |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 2 | Hitting way, 0 on a miss |
| fill_valid | input | 1 | Install a line tag |
| fill_index | input | 7 | Set index of the fill |
| fill_tag | input | 20 | Physical tag to install |
| fill_victim | output | 2 | Way the fill writes (LRU of `fill_index`) |

## Verification
The delicate case is a hit's LRU update and a line fill landing on the same set in the same cycle. This is provoked by driving `fill_valid` into the pending set on the very cycle `xlat_valid` returns a matching page. The victim shown in that cycle must be the way that was oldest before it. The replacement order that follows, observed through later fills' `fill_victim`, must show the filled way newest and the hit way next. A fill whose tag equals the pending page number in that same cycle is also checked to report a miss, followed by a hit on a fresh lookup.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Extract a field of idx_w bits starting at bit off_w of an address.
  function automatic int unsigned addr_field(logic [63:0] addr, int off_w, int idx_w);
    logic [63:0] mask;
    mask = (64'd1 << idx_w) - 64'd1;
    return int'((addr >> off_w) & mask);
  endfunction

endpackage

// File: rtl/vipt_init_ctrl.sv
module vipt_init_ctrl #(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             done
);

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + IDX_W'(1);
      if (cnt_q == IDX_W'(SETS - 1)) busy_q <= 1'b0;
    end
  end

  assign clr_en  = busy_q;
  assign clr_idx = cnt_q;
  assign done    = !busy_q;

  // R8: once the sweep ends it stays ended until the next reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8: the sweep ends only after the last set was cleared
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt_q) == IDX_W'(SETS - 1));

endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_idx,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  output logic [WAYS-1:0][TAG_W-1:0]  hold_tag,
  output logic [WAYS-1:0]             hold_val
);

  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            val_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] hold_tag_q;
  logic [WAYS-1:0]            hold_val_q;

  // array updates: clearing sweep has priority over fills
  always_ff @(posedge clk) begin
    if (clr_en) begin
      val_q[clr_idx] <= '0;
    end else if (wr_en) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
      val_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  // registered read of one set; held until the next read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_tag_q <= '0;
      hold_val_q <= '0;
    end else if (rd_en) begin
      hold_tag_q <= tag_q[rd_idx];
      hold_val_q <= val_q[rd_idx];
    end
  end

  assign hold_tag = hold_tag_q;
  assign hold_val = hold_val_q;

  // R6: a filled way reads back valid with the written tag
  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> (val_q[$past(wr_idx)][$past(wr_way)] &&
                            tag_q[$past(wr_idx)][$past(wr_way)] == $past(wr_tag)));

endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  output logic [WAY_W-1:0] fill_way
);

  typedef logic [WAYS-1:0][WAY_W-1:0] age_t;

  // age 0 = most recent, WAYS-1 = oldest; ages of a set form a permutation
  function automatic age_t age_reset();
    age_t r;
    for (int k = 0; k < WAYS; k++) r[k] = WAY_W'(k);
    return r;
  endfunction

  function automatic age_t age_touch(age_t a, logic [WAY_W-1:0] w);
    age_t r;
    r = a;
    for (int k = 0; k < WAYS; k++)
      if (a[k] < a[w]) r[k] = a[k] + WAY_W'(1);
    r[w] = '0;
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] age_oldest(age_t a);
    logic [WAY_W-1:0] v;
    v = '0;
    for (int k = 0; k < WAYS; k++)
      if (a[k] == WAY_W'(WAYS - 1)) v = WAY_W'(k);
    return v;
  endfunction

  age_t age_q [SETS];
  logic same_set;

  assign fill_way = age_oldest(age_q[fill_idx]);
  assign same_set = hit_en && fill_en && (hit_idx == fill_idx);

  always_ff @(posedge clk) begin
    if (clr_en) begin
      age_q[clr_idx] <= age_reset();
    end else if (same_set) begin
      age_q[hit_idx] <= age_touch(age_touch(age_q[hit_idx], hit_way), fill_way);
    end else begin
      if (hit_en)  age_q[hit_idx]  <= age_touch(age_q[hit_idx], hit_way);
      if (fill_en) age_q[fill_idx] <= age_touch(age_q[fill_idx], fill_way);
    end
  end

  // R6 / R9: the filled way is the newest afterwards
  p_fill_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !clr_en) |=> age_q[$past(fill_idx)][$past(fill_way)] == '0);

  // R7: a lone hit makes its way the newest
  p_hit_newest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !clr_en && !same_set) |=> age_q[$past(hit_idx)][$past(hit_way)] == '0);

  // R9: with a fill in the same set, the hit way ends second newest unless it was the victim
  p_shared_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (same_set && !clr_en && hit_way != fill_way) |=>
      age_q[$past(hit_idx)][$past(hit_way)] == WAY_W'(1));

endmodule

// File: rtl/vipt_compare.sv
module vipt_compare #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] hold_tag,
  input  logic [WAYS-1:0]            hold_val,
  input  logic [TAG_W-1:0]           ppn,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  function automatic logic [WAY_W-1:0] way_encode(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] w;
    w = '0;
    for (int k = 0; k < WAYS; k++)
      if (v[k]) w = WAY_W'(k);
    return w;
  endfunction

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign hit_vec[g] = hold_val[g] && (hold_tag[g] == ppn);
  end

  assign hit     = |hit_vec;
  assign hit_way = way_encode(hit_vec);

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int VA_W   = 32,
  parameter int LINE_B = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             req_ready,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             xlat_valid,
  input  logic             xlat_fault,
  input  logic [TAG_W-1:0] xlat_ppn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [WAY_W-1:0] resp_way,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_index,
  input  logic [TAG_W-1:0] fill_tag,
  output logic [WAY_W-1:0] fill_victim
);

  // named internal events
  logic                       init_done;
  logic                       clr_en;
  logic [IDX_W-1:0]           clr_idx;
  logic                       req_take;
  logic [IDX_W-1:0]           req_idx;
  logic                       xlat_take;
  logic                       fill_take;
  logic                       pending_q;
  logic [IDX_W-1:0]           pend_idx_q;
  logic [WAYS-1:0][TAG_W-1:0] hold_tag;
  logic [WAYS-1:0]            hold_val;
  logic [WAYS-1:0]            hit_vec;
  logic                       cmp_hit;
  logic [WAY_W-1:0]           cmp_way;
  logic                       hit_event;

  assign req_ready = init_done && !pending_q;
  assign req_take  = req_valid && req_ready;
  assign req_idx   = IDX_W'(vipt_pkg::addr_field(64'(req_vaddr), OFF_W, IDX_W));
  assign xlat_take = pending_q && xlat_valid;
  assign fill_take = fill_valid && init_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      pend_idx_q <= '0;
    end else if (req_take) begin
      pending_q  <= 1'b1;
      pend_idx_q <= req_idx;
    end else if (xlat_take) begin
      pending_q  <= 1'b0;
    end
  end

  vipt_init_ctrl #(.SETS(SETS)) u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .done    (init_done)
  );

  vipt_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .rd_en    (req_take),
    .rd_idx   (req_idx),
    .wr_en    (fill_take),
    .wr_idx   (fill_index),
    .wr_way   (fill_victim),
    .wr_tag   (fill_tag),
    .hold_tag (hold_tag),
    .hold_val (hold_val)
  );

  vipt_compare #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .hold_tag (hold_tag),
    .hold_val (hold_val),
    .ppn      (xlat_ppn),
    .hit_vec  (hit_vec),
    .hit      (cmp_hit),
    .hit_way  (cmp_way)
  );

  assign resp_valid = xlat_take && !xlat_fault;
  assign hit_event  = resp_valid && cmp_hit;
  assign resp_hit   = hit_event;
  assign resp_way   = hit_event ? cmp_way : '0;

  vipt_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .hit_en   (hit_event),
    .hit_idx  (pend_idx_q),
    .hit_way  (cmp_way),
    .fill_en  (fill_take),
    .fill_idx (fill_index),
    .fill_way (fill_victim)
  );

  // R2: a taken request blocks new ones in the following cycle
  p_block_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> !req_ready);

  // R3: held tags do not move while translation is outstanding
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !xlat_valid) |=> ($stable(hold_tag) && $stable(hold_val)));

  // R3 / R5: translation, faulting or not, ends the pending lookup
  p_xlat_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && xlat_valid) |=> !pending_q);

  // R4: at most one way matches
  p_one_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot0(hit_vec));

  // R8: no request can be taken before the sweep ends
  p_ready_after_sweep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !req_ready);

endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_ready;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        xlat_valid = 1'b0;
  logic        xlat_fault = 1'b0;
  logic [19:0] xlat_ppn = '0;
  logic        resp_valid;
  logic        resp_hit;
  logic [1:0]  resp_way;
  logic        fill_valid = 1'b0;
  logic [6:0]  fill_index = '0;
  logic [19:0] fill_tag = '0;
  logic [1:0]  fill_victim;

  always #5 clk = ~clk;

  vipt_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .xlat_valid(xlat_valid), .xlat_fault(xlat_fault),
    .xlat_ppn(xlat_ppn), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .fill_valid(fill_valid), .fill_index(fill_index),
    .fill_tag(fill_tag), .fill_victim(fill_victim)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model: stored tags, valid flags, recency list (index 0 = newest)
  logic [19:0] m_tag [128][4];
  bit          m_vld [128][4];
  int          m_ord [128][4];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_touch(int s, int w);
    int pos = 0;
    for (int k = 0; k < 4; k++) if (m_ord[s][k] == w) pos = k;
    for (int k = pos; k > 0; k--) m_ord[s][k] = m_ord[s][k-1];
    m_ord[s][0] = w;
  endtask

  task automatic do_fill(int s, logic [19:0] t, string req);
    int v;
    @(negedge clk);
    fill_valid = 1'b1; fill_index = 7'(s); fill_tag = t;
    #1;
    v = m_ord[s][3];
    chk(fill_victim == 2'(v), req, fill_victim, v);
    m_touch(s, v);
    m_tag[s][v] = t; m_vld[s][v] = 1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_lookup(logic [31:0] va, logic [19:0] ppn, int lag, bit fault,
                           bit fill_now, logic [19:0] ftag, string req);
    int s, ew, v;
    bit eh;
    s = int'(va[11:5]);
    eh = 0; ew = 0;
    for (int w = 0; w < 4; w++)
      if (m_vld[s][w] && m_tag[s][w] == ppn) begin eh = 1; ew = w; end
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy while pending", req_ready, 0);
    for (int i = 0; i < lag; i++) begin
      chk(resp_valid == 1'b0, "R3 no response before translation", resp_valid, 0);
      @(negedge clk);
    end
    xlat_valid = 1'b1; xlat_ppn = ppn; xlat_fault = fault;
    if (fill_now) begin
      fill_valid = 1'b1; fill_index = 7'(s); fill_tag = ftag;
    end
    #1;
    if (fault) begin
      chk(resp_valid == 1'b0, "R5 fault gives no response", resp_valid, 0);
    end else begin
      chk(resp_valid == 1'b1, req, resp_valid, 1);
      chk(resp_hit == eh, req, resp_hit, eh);
      chk(resp_way == 2'(eh ? ew : 0), req, resp_way, eh ? ew : 0);
    end
    v = m_ord[s][3];
    if (fill_now) chk(fill_victim == 2'(v), "R9 victim from prior state", fill_victim, v);
    if (!fault && eh) m_touch(s, ew);
    if (fill_now) begin
      m_touch(s, v); m_tag[s][v] = ftag; m_vld[s][v] = 1;
    end
    @(negedge clk);
    xlat_valid = 1'b0; xlat_fault = 1'b0; fill_valid = 1'b0;
    chk(req_ready == 1'b1, "R2 ready after translation", req_ready, 1);
  endtask

  function automatic logic [31:0] mkva(logic [19:0] hi, int s, int off);
    return {hi, 7'(s), 5'(off)};
  endfunction

  task automatic t_reset();
    int n = 0;
    for (int s = 0; s < 128; s++)
      for (int k = 0; k < 4; k++) begin m_ord[s][k] = k; m_vld[s][k] = 0; m_tag[s][k] = '0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R8 not ready in reset", req_ready, 0);
    rst_n = 1'b1;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    chk(n == 128, "R8 sweep length", n, 128);
    do_lookup(mkva(20'h12345, 5, 3), 20'h00000, 0, 0, 0, '0, "R8 cleared lines miss");
  endtask

  task automatic t_fill_order();
    do_fill(10, 20'hA0000, "R8 first victim way 3");
    do_fill(10, 20'hA0001, "R8 second victim way 2");
    do_fill(10, 20'hA0002, "R8 third victim way 1");
    do_fill(10, 20'hA0003, "R8 fourth victim way 0");
  endtask

  task automatic t_hit_miss();
    do_lookup(mkva(20'hFFFFF, 10, 31), 20'hA0001, 0, 0, 0, '0, "R4 hit way 2 / R1 offset ignored");
    do_lookup(mkva(20'h00000, 10, 0),  20'hA0003, 0, 0, 0, '0, "R4 hit way 0 / R1 upper bits ignored");
    do_lookup(mkva(20'h5A5A5, 10, 7),  20'hA0007, 0, 0, 0, '0, "R4 miss on tag mismatch");
    do_lookup(mkva(20'hA0000, 11, 0),  20'hA0000, 0, 0, 0, '0, "R1 neighbour set misses");
  endtask

  task automatic t_lru_hit();
    // after hits on ways 2 and 0, way 3 (tag A0000) is oldest
    do_fill(10, 20'hB0000, "R7 hits steer the victim");
    do_fill(10, 20'hB0001, "R7 next victim after hits");
  endtask

  task automatic t_late();
    do_lookup(mkva(20'h1, 10, 4), 20'hB0000, 5, 0, 0, '0, "R3 late translation hit");
    do_lookup(mkva(20'h2, 10, 4), 20'hB0001, 2, 0, 0, '0, "R3 late translation hit 2");
  endtask

  task automatic t_fault();
    do_lookup(mkva(20'h3, 10, 0), 20'hA0003, 1, 1, 0, '0, "R5 cancel");
    do_fill(10, 20'hC0000, "R5 fault left LRU untouched");
  endtask

  task automatic t_same_cycle();
    do_fill(30, 20'hD0000, "R6 fill set 30");
    do_fill(30, 20'hD0001, "R6 fill set 30 second");
    do_lookup(mkva(20'h0, 30, 0), 20'hD0000, 0, 0, 1, 20'hD0002, "R9 hit with fill same cycle");
    do_fill(30, 20'hD0003, "R9 order after shared cycle");
    do_fill(30, 20'hD0004, "R9 order after shared cycle 2");
    do_fill(30, 20'hD0005, "R9 order after shared cycle 3");
  endtask

  task automatic t_snapshot();
    do_lookup(mkva(20'h7, 40, 0), 20'hE1234, 1, 0, 1, 20'hE1234, "R10 fill during pending keeps miss");
    do_lookup(mkva(20'h7, 40, 9), 20'hE1234, 0, 0, 0, '0, "R10 later lookup hits filled line");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_order();
    t_hit_miss();
    t_lru_hit();
    t_late();
    t_fault();
    t_same_cycle();
    t_snapshot();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule